// File: doc/BRIEF.md
# Decode-Stage Instruction Exception Classifier

This block sits beside the decode stage of a small in-order processor. Each cycle it looks at the class flags of the instruction being decoded, at whether that instruction occupies the slot after a delayed branch, at whether the floating-point unit is powered down, and at the operands of a divide in the execute stage. From these it decides whether an instruction exception must be raised and which one. At most one exception is reported per cycle: a registered one-cycle `exc_valid` pulse, a one-hot request vector and a 3-bit cause code.

Delay-slot tracking is a two-state machine. In `SLOT_IDLE`, a decoded delayed branch takes the transition *arm* to `SLOT_ARMED`. In `SLOT_ARMED`, the next decoded instruction takes the transition *consume* back to `SLOT_IDLE`. A decoded delayed branch in that slot does not re-arm the machine. A pipeline flush takes the transition *abort* to `SLOT_IDLE` from either state. Cycles with no decoded instruction keep the state.

A trap instruction is not reported at decode. It is held for one stage and reported when it reaches execute. The exception is therefore registered two cycles after the trap was presented at decode.

Top module: `iexc_classifier`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `exc_valid` is 0, `exc_req` is 0, `exc_cause` is 0 and no delay slot is pending.
- R2: An instruction decoded outside a delay slot that is undefined (class bit 0) yields, one cycle later, cause 1 (general illegal) with `exc_req` bit 0.
- R3: An instruction decoded in a delay slot that is undefined, or that writes the PC (bit 2), is 32 bits long (bit 3), restores the register bank (bit 4), or is a signed divide (bit 5) or unsigned divide (bit 6), yields, one cycle later, cause 2 (slot illegal) with `exc_req` bit 1.
- R4: A delay slot covers exactly the next decoded instruction after a delayed branch. Cycles with `dec_valid` low do not consume it. An instruction decoded after the slot is judged as normal.
- R5: While `fpu_standby` is 1, an FPU-related instruction (bit 7) counts as undefined and follows R2 and R3. While `fpu_standby` is 0, it raises nothing.
- R6: A trap instruction (bit 1) that is not itself illegal yields cause 3 with `exc_req` bit 2 two cycles after its decode cycle, and nothing one cycle after it.
- R7: An execute-stage divide, signed or unsigned, with a zero divisor yields, one cycle later, cause 4 with `exc_req` bit 3.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF yields, one cycle later, cause 5 with `exc_req` bit 3. The same operands in an unsigned divide raise nothing, and so does a signed divide of 0x80000000 by 1.
- R9: When several causes hold in one cycle, only the highest is reported. The order is slot illegal, then general illegal, then divide by zero, then divide overflow, then trap.
- R10: `exc_valid` is high only in a cycle that reports a cause. In such a cycle exactly one `exc_req` bit is set. Otherwise `exc_req` and `exc_cause` are 0.
- R11: `flush` suppresses any report for that cycle, discards a trap awaiting execute, and clears a pending delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush |
| dec_valid | input | 1 | An instruction is in decode this cycle |
| dec_class | input | 8 | Class flags of the decoded instruction (bit map in R2 to R6) |
| dec_dbranch | input | 1 | The decoded instruction is a delayed branch |
| fpu_standby | input | 1 | FPU is powered down |
| ex_div_valid | input | 1 | A divide is in execute this cycle |
| ex_div_signed | input | 1 | The executing divide is signed |
| ex_dividend | input | XLEN | Dividend of the executing divide |
| ex_divisor | input | XLEN | Divisor of the executing divide |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_req | output | 4 | One-hot request: general, slot, trap, divide |
| exc_cause | output | 3 | Cause code, 0 when none |

## Verification
Assertions check the following on every cycle: the one-hot/cause consistency of the outputs, the single-instruction life of the delay slot, the clearing effect of a flush, and the fixed latency of general-illegal, slot-illegal, divide-by-zero and trap reports when no competing cause is present. The full priority order among simultaneous causes can only be shown by the bench's scenarios. The same holds for the FPU-standby remapping, the overflow operand corner (and its unsigned and divide-by-one counterparts), and a slot that survives idle decode cycles. The bench compares every cycle against its own reference model.

// File: rtl/iexc_pkg.sv
package iexc_pkg;

    localparam int CLS_W = 8;
    localparam int REQ_W = 4;
    localparam int CAUSE_W = 3;

    // class flag positions on the decoded-opcode bus
    localparam int CL_UNDEF = 0;
    localparam int CL_TRAP  = 1;
    localparam int CL_PCWR  = 2;
    localparam int CL_LONG  = 3;
    localparam int CL_BANK  = 4;
    localparam int CL_DIVS  = 5;
    localparam int CL_DIVU  = 6;
    localparam int CL_FPU   = 7;

    // kinds that are legal in normal flow but forbidden in a delay slot
    localparam logic [CLS_W-1:0] SLOT_FORBID =
        (CLS_W'(1) << CL_PCWR) | (CLS_W'(1) << CL_LONG) | (CLS_W'(1) << CL_BANK) |
        (CLS_W'(1) << CL_DIVS) | (CLS_W'(1) << CL_DIVU);

    // one-hot request positions
    localparam int RQ_GEN  = 0;
    localparam int RQ_SLOT = 1;
    localparam int RQ_TRAP = 2;
    localparam int RQ_DIV  = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_GEN_ILL  = 3'd1,
        CAUSE_SLOT_ILL = 3'd2,
        CAUSE_TRAP     = 3'd3,
        CAUSE_DIV_ZERO = 3'd4,
        CAUSE_DIV_OVF  = 3'd5
    } cause_e;

    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic slot_ill;
        logic gen_ill;
        logic div_zero;
        logic div_ovf;
        logic trap;
    } hits_t;

    function automatic int unsigned req_pos(cause_e c);
        unique case (c)
            CAUSE_GEN_ILL:  return RQ_GEN;
            CAUSE_SLOT_ILL: return RQ_SLOT;
            CAUSE_TRAP:     return RQ_TRAP;
            default:        return RQ_DIV;
        endcase
    endfunction

endpackage

// File: rtl/iexc_slot_fsm.sv
module iexc_slot_fsm
    import iexc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic dec_valid,
    input  logic dec_dbranch,
    output logic in_slot
);

    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (flush)                          state_d = SLOT_IDLE;   // abort
                else if (dec_valid && dec_dbranch)  state_d = SLOT_ARMED;  // arm
            end
            SLOT_ARMED: begin
                if (flush)          state_d = SLOT_IDLE;                   // abort
                else if (dec_valid) state_d = SLOT_IDLE;                   // consume
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    always_comb begin
        in_slot = (state_q == SLOT_ARMED);
    end

endmodule

// File: rtl/iexc_detect.sv
module iexc_detect
    import iexc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             flush,
    input  logic             in_slot,
    input  logic             trap_q,
    input  logic             dec_valid,
    input  logic [CLS_W-1:0] dec_class,
    input  logic             fpu_standby,
    input  logic             ex_div_valid,
    input  logic             ex_div_signed,
    input  logic [XLEN-1:0]  ex_dividend,
    input  logic [XLEN-1:0]  ex_divisor,
    output hits_t            hits,
    output logic             trap_arm
);

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] MINUS_1  = {XLEN{1'b1}};

    logic undef_eff;
    logic forbid_any;
    logic dec_live;

    always_comb begin
        dec_live   = dec_valid && !flush;
        undef_eff  = dec_class[CL_UNDEF] || (fpu_standby && dec_class[CL_FPU]);
        forbid_any = |(dec_class & SLOT_FORBID);

        hits          = '0;
        hits.slot_ill = dec_live && in_slot && (undef_eff || forbid_any);
        hits.gen_ill  = dec_live && !in_slot && undef_eff;
        hits.div_zero = ex_div_valid && !flush && (ex_divisor == '0);
        hits.div_ovf  = ex_div_valid && !flush && ex_div_signed &&
                        (ex_dividend == MOST_NEG) && (ex_divisor == MINUS_1);
        hits.trap     = trap_q && !flush;

        trap_arm = dec_live && dec_class[CL_TRAP] && !hits.slot_ill && !hits.gen_ill;
    end

endmodule

// File: rtl/iexc_arbiter.sv
module iexc_arbiter
    import iexc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  hits_t              hits,
    output logic               exc_valid,
    output logic [REQ_W-1:0]   exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);

    cause_e             cause_d;
    logic [REQ_W-1:0]   req_d;
    logic               valid_q;
    logic [REQ_W-1:0]   req_q;
    cause_e             cause_q;

    always_comb begin
        if      (hits.slot_ill) cause_d = CAUSE_SLOT_ILL;
        else if (hits.gen_ill)  cause_d = CAUSE_GEN_ILL;
        else if (hits.div_zero) cause_d = CAUSE_DIV_ZERO;
        else if (hits.div_ovf)  cause_d = CAUSE_DIV_OVF;
        else if (hits.trap)     cause_d = CAUSE_TRAP;
        else                    cause_d = CAUSE_NONE;
    end

    for (genvar i = 0; i < REQ_W; i++) begin : g_req
        always_comb begin
            req_d[i] = (cause_d != CAUSE_NONE) && (req_pos(cause_d) == i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            req_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            valid_q <= (cause_d != CAUSE_NONE);
            req_q   <= req_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        exc_valid = valid_q;
        exc_req   = req_q;
        exc_cause = cause_q;
    end

endmodule

// File: rtl/iexc_classifier.sv
module iexc_classifier
    import iexc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               dec_valid,
    input  logic [CLS_W-1:0]   dec_class,
    input  logic               dec_dbranch,
    input  logic               fpu_standby,
    input  logic               ex_div_valid,
    input  logic               ex_div_signed,
    input  logic [XLEN-1:0]    ex_dividend,
    input  logic [XLEN-1:0]    ex_divisor,
    output logic               exc_valid,
    output logic [REQ_W-1:0]   exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);

    logic  in_slot;
    logic  trap_q;
    logic  trap_arm;
    hits_t hits;

    iexc_slot_fsm u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .dec_valid   (dec_valid),
        .dec_dbranch (dec_dbranch),
        .in_slot     (in_slot)
    );

    iexc_detect #(.XLEN(XLEN)) u_det (
        .flush         (flush),
        .in_slot       (in_slot),
        .trap_q        (trap_q),
        .dec_valid     (dec_valid),
        .dec_class     (dec_class),
        .fpu_standby   (fpu_standby),
        .ex_div_valid  (ex_div_valid),
        .ex_div_signed (ex_div_signed),
        .ex_dividend   (ex_dividend),
        .ex_divisor    (ex_divisor),
        .hits          (hits),
        .trap_arm      (trap_arm)
    );

    // trap travels one stage to execute before it is reported
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= trap_arm;
    end

    iexc_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hits),
        .exc_valid (exc_valid),
        .exc_req   (exc_req),
        .exc_cause (exc_cause)
    );

endmodule

// File: rtl/iexc_checker.sv
module iexc_checker
    import iexc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               dec_valid,
    input logic [CLS_W-1:0]   dec_class,
    input logic               ex_div_valid,
    input logic [XLEN-1:0]    ex_divisor,
    input logic               in_slot,
    input logic               trap_q,
    input logic               exc_valid,
    input logic [REQ_W-1:0]   exc_req,
    input logic [CAUSE_W-1:0] exc_cause
);

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($countones(exc_req) == 1)); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_req == '0 && exc_cause == '0)); // R10

    AST_GEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !flush && !in_slot && dec_class[CL_UNDEF])
        |=> (exc_valid && exc_cause == 3'd1 && exc_req[RQ_GEN])); // R2

    AST_SLOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !flush && in_slot && ((dec_class & (SLOT_FORBID | CLS_W'(1))) != '0))
        |=> (exc_cause == 3'd2 && exc_req[RQ_SLOT])); // R3

    AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && dec_valid) |=> !in_slot); // R4

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!in_slot && !trap_q && !exc_valid)); // R11

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_div_valid && !flush && !dec_valid && ex_divisor == '0)
        |=> (exc_cause == 3'd4 && exc_req[RQ_DIV])); // R7

    AST_TRAP_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_q && !flush && !dec_valid && !ex_div_valid)
        |=> (exc_cause == 3'd3 && exc_req[RQ_TRAP])); // R6

endmodule

bind iexc_classifier iexc_checker #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .dec_valid    (dec_valid),
    .dec_class    (dec_class),
    .ex_div_valid (ex_div_valid),
    .ex_divisor   (ex_divisor),
    .in_slot      (in_slot),
    .trap_q       (trap_q),
    .exc_valid    (exc_valid),
    .exc_req      (exc_req),
    .exc_cause    (exc_cause)
);

// File: tb/sim_iexc_classifier.sv
`timescale 1ns/1ps
module sim_iexc_classifier;

    localparam int XLEN = 32;
    localparam logic [31:0] MNEG = 32'h8000_0000;
    localparam logic [31:0] NEG1 = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        dec_valid;
    logic [7:0]  dec_class;
    logic        dec_dbranch;
    logic        fpu_standby;
    logic        ex_div_valid;
    logic        ex_div_signed;
    logic [31:0] ex_dividend;
    logic [31:0] ex_divisor;
    logic        exc_valid;
    logic [3:0]  exc_req;
    logic [2:0]  exc_cause;

    int errs = 0;
    int checks = 0;
    bit m_slot = 0;
    bit m_trap = 0;

    always #4 clk = ~clk;

    iexc_classifier #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dec_valid(dec_valid),
        .dec_class(dec_class), .dec_dbranch(dec_dbranch), .fpu_standby(fpu_standby),
        .ex_div_valid(ex_div_valid), .ex_div_signed(ex_div_signed),
        .ex_dividend(ex_dividend), .ex_divisor(ex_divisor),
        .exc_valid(exc_valid), .exc_req(exc_req), .exc_cause(exc_cause)
    );

    function automatic logic [3:0] req_of(logic [2:0] c);
        case (c)
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0100;
            3'd4, 3'd5: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(bit dv, logic [7:0] cls, bit dbr, bit fl, bit fs,
                         bit ev, bit es, logic [31:0] dd, logic [31:0] dr);
        dec_valid = dv; dec_class = cls; dec_dbranch = dbr; flush = fl;
        fpu_standby = fs; ex_div_valid = ev; ex_div_signed = es;
        ex_dividend = dd; ex_divisor = dr;
    endtask

    task automatic idle();
        drive(0, 8'h00, 0, 0, 0, 0, 0, 32'd5, 32'd3);
    endtask

    // reference model: one clock, then compare registered outputs
    task automatic step(string tag);
        bit undef, sl, gn, dz, dov, tr, nslot, ntrap;
        logic [2:0] ec;
        string t;
        undef = dec_class[0] || (fpu_standby && dec_class[7]);
        sl  = !flush && dec_valid && m_slot && (undef || (dec_class[6:2] != 0));
        gn  = !flush && dec_valid && !m_slot && undef;
        dz  = !flush && ex_div_valid && ex_divisor == 0;
        dov = !flush && ex_div_valid && ex_div_signed && ex_dividend == MNEG && ex_divisor == NEG1;
        tr  = !flush && m_trap;
        ec = sl ? 3'd2 : gn ? 3'd1 : dz ? 3'd4 : dov ? 3'd5 : tr ? 3'd3 : 3'd0;
        nslot = flush ? 1'b0 : (dec_valid ? (!m_slot && dec_dbranch) : m_slot);
        ntrap = !flush && dec_valid && dec_class[1] && !sl && !gn;
        @(posedge clk);
        #1;
        t = (tag == "") ? tag_of(ec) : tag;
        checks++;
        if (exc_valid !== (ec != 0) || exc_cause !== ec || exc_req !== req_of(ec)) begin
            errs++;
            $display("FAIL %s: valid=%0b cause=%0d req=%b expected valid=%0b cause=%0d req=%b",
                     t, exc_valid, exc_cause, exc_req, ec != 0, ec, req_of(ec));
        end
        m_slot = nslot;
        m_trap = ntrap;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        checks++;
        if (exc_valid !== 0 || exc_req !== 0 || exc_cause !== 0) begin
            errs++;
            $display("FAIL R1: valid=%0b req=%b cause=%0d expected 0 0 0", exc_valid, exc_req, exc_cause);
        end
        // R3 style input held during reset must leave no slot pending
        drive(1, 8'h00, 1, 0, 0, 0, 0, 0, 1);
        @(posedge clk); #1;
        rst_n = 1;
        idle(); step("R1");
        drive(1, 8'h04, 0, 0, 0, 0, 0, 0, 1); step("R1");   // pc write, no slot after reset
        idle(); step("R1");

        drive(1, 8'h01, 0, 0, 0, 0, 0, 0, 1); step("R2");
        idle(); step("R10");                                // strobe is one cycle

        for (int k = 0; k < 6; k++) begin                   // R3 each forbidden kind
            drive(1, 8'h04, 1, 0, 0, 0, 0, 0, 1); step("R3");
            drive(1, (k == 0) ? 8'h01 : 8'(1 << (k + 1)), 0, 0, 0, 0, 0, 0, 1); step("R3");
        end
        idle(); step("R3");

        drive(1, 8'h04, 1, 0, 0, 0, 0, 0, 1); step("R4");
        idle(); step("R4");
        idle(); step("R4");
        drive(1, 8'h08, 0, 0, 0, 0, 0, 0, 1); step("R4");  // slot still pending
        drive(1, 8'h08, 0, 0, 0, 0, 0, 0, 1); step("R4");  // slot consumed
        idle(); step("R4");

        drive(1, 8'h80, 0, 0, 1, 0, 0, 0, 1); step("R5");
        drive(1, 8'h80, 0, 0, 0, 0, 0, 0, 1); step("R5");
        drive(1, 8'h04, 1, 0, 1, 0, 0, 0, 1); step("R5");
        drive(1, 8'h80, 0, 0, 1, 0, 0, 0, 1); step("R5");
        drive(1, 8'h04, 1, 0, 0, 0, 0, 0, 1); step("R5");
        drive(1, 8'h80, 0, 0, 0, 0, 0, 0, 1); step("R5");  // legal in slot when powered
        idle(); step("R5");

        drive(1, 8'h02, 0, 0, 0, 0, 0, 0, 1); step("R6");
        idle(); step("R6");
        idle(); step("R6");

        drive(0, 8'h00, 0, 0, 0, 1, 1, 32'd77, 32'd0); step("R7");
        drive(0, 8'h00, 0, 0, 0, 1, 0, 32'd77, 32'd0); step("R7");
        drive(0, 8'h00, 0, 0, 0, 1, 1, MNEG, NEG1); step("R8");
        drive(0, 8'h00, 0, 0, 0, 1, 0, MNEG, NEG1); step("R8");
        drive(0, 8'h00, 0, 0, 0, 1, 1, MNEG, 32'd1); step("R8");
        idle(); step("R8");

        drive(1, 8'h04, 1, 0, 0, 0, 0, 0, 1); step("R9");
        drive(1, 8'h01, 0, 0, 0, 1, 1, 32'd3, 32'd0); step("R9");
        drive(1, 8'h01, 0, 0, 0, 1, 1, 32'd3, 32'd0); step("R9");
        drive(1, 8'h02, 0, 0, 0, 0, 0, 0, 1); step("R9");
        drive(0, 8'h00, 0, 0, 0, 1, 1, MNEG, NEG1); step("R9");
        idle(); step("R9");

        drive(1, 8'h04, 1, 0, 0, 0, 0, 0, 1); step("R11");
        drive(0, 8'h00, 0, 1, 0, 1, 1, 0, 0); step("R11");
        drive(1, 8'h04, 0, 0, 0, 0, 0, 0, 1); step("R11");
        drive(1, 8'h02, 0, 0, 0, 0, 0, 0, 1); step("R11");
        drive(0, 8'h00, 0, 1, 0, 0, 0, 0, 1); step("R11");
        idle(); step("R11");

        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [7:0] cls;
            logic [31:0] dr, dd;
            r = $urandom % 12;
            cls = (r < 8) ? 8'(1 << r) : (r == 8) ? 8'($urandom) : 8'h00;
            dr = ($urandom % 4 == 0) ? 32'd0 : ($urandom % 3 == 0) ? NEG1 : $urandom;
            dd = ($urandom % 3 == 0) ? MNEG : $urandom;
            drive($urandom % 4 != 0, cls, $urandom % 4 == 0, $urandom % 16 == 0,
                  $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 2 == 0, dd, dr);
            step("");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule